// File: doc/BRIEF.md
# PLL Fastlock Sequencer

This block opens a temporary fast-acquisition window each time the main divider of a PLL is reprogrammed. A 16-bit write-only configuration word holds an enable bit, a two-stage timer setting (coarse power-of-two prescale and fine count) and a 2-bit charge-pump current code used only during the window. The normal 4-bit charge-pump current code arrives on its own input.

When a divider-update strobe is seen with fastlock enabled, the sequencer pulls an open-drain pin low, routes the fastlock current code to the charge-pump select output and starts its timer. When the timer runs out, the pin returns to high impedance, the normal current code is restored and a one-cycle done pulse is given. A further update during the window restarts the timer. Clearing the enable bit cuts the window short.

Top module: `fastlock_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, fl_pin_oe, fl_pin_o and fl_done are 0, and the configuration word is all zeros, so fastlock is disabled.
- R2: With configuration bit 12 (enable) at 0, a div_upd strobe leaves fl_pin_oe at 0, and cp_cur_sel keeps following the normal current code.
- R3: With bit 12 at 1, a div_upd strobe sets fl_pin_oe to 1 from the next clock edge, with fl_pin_o held at 0.
- R4: The window lasts (fine + 1) × 2^coarse clock cycles, where coarse is bits 11:9 and fine is bits 8:2 of the configuration word, both sampled at the strobe.
- R5: cp_cur_sel is registered. While fl_pin_oe is 1 it carries bits 1:0 of the configuration word, zero-extended. Otherwise it carries norm_cur as sampled one cycle earlier.
- R6: A div_upd strobe during an active window reloads the timer, so the window ends a full duration after the last strobe.
- R7: If the enable bit is written to 0 during a window, fl_pin_oe drops at the clock edge after the write edge, and no done pulse is given.
- R8: fl_done is high for exactly one cycle: the first cycle in which fl_pin_oe is 0 after a window that ran to expiry.
- R9: Writes to bits 15:13 are discarded and have no effect on behaviour.
- R10: A configuration write and a div_upd strobe in the same cycle: the strobe acts on the configuration held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| div_upd | input | 1 | Main-divider update strobe, one cycle |
| norm_cur | input | 4 | Normal charge-pump current code |
| fl_pin_oe | output | 1 | Open-drain pin output enable (1 = pull low) |
| fl_pin_o | output | 1 | Open-drain pin data, always 0 |
| cp_cur_sel | output | 4 | Charge-pump current select |
| fl_done | output | 1 | One-cycle pulse at timer expiry |

## Verification
The states that are hardest to reach from the ports are a second update that lands in the middle of a running window, and an enable clear during a long window. For these, the bench issues the second strobe a few cycles after the first and then measures the remaining window from the second strobe only. For the enable clear, it starts a window of maximum length, rewrites the configuration with the enable bit low, and checks both the cycle in which the pin releases and that fl_done stays low. A configuration write in the same cycle as a strobe is also driven, to show which configuration the strobe uses.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
  typedef enum logic {FL_IDLE = 1'b0, FL_RUN = 1'b1} fl_state_e;
endpackage

// File: rtl/fl_cfg_reg.sv
module fl_cfg_reg #(
  parameter int REG_W   = 16,
  parameter int RSV_LSB = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] keep_mask;

  always_comb begin
    for (int i = 0; i < REG_W; i++) keep_mask[i] = (i < RSV_LSB);
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & keep_mask;
  end
endmodule

// File: rtl/fl_timer.sv
module fl_timer
  import fastlock_pkg::*;
#(
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                start,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  output logic                run_d,
  output logic                expire
);
  localparam int PRE_W = (2 ** COARSE_W) - 1;

  fl_state_e              st_q;
  logic [PRE_W-1:0]       pre_q;
  logic [PRE_W-1:0]       pre_mask;
  logic [FINE_W-1:0]      cnt_q;
  logic [COARSE_W-1:0]    coarse_q;
  logic                   load;
  logic                   tick;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_mask[i] = (i < int'(coarse_q));
  end

  assign load   = start && en;
  assign tick   = ((pre_q & pre_mask) == pre_mask);
  assign expire = (st_q == FL_RUN) && en && !load && tick && (cnt_q == '0);

  always_comb begin
    if (load)                       run_d = 1'b1;
    else if (!en || expire)         run_d = 1'b0;
    else                            run_d = (st_q == FL_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FL_IDLE;
      pre_q    <= '0;
      cnt_q    <= '0;
      coarse_q <= '0;
    end else begin
      st_q <= run_d ? FL_RUN : FL_IDLE;
      if (load) begin
        pre_q    <= '0;
        cnt_q    <= fine;
        coarse_q <= coarse;
      end else if (st_q == FL_RUN) begin
        if (tick) begin
          pre_q <= '0;
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fl_drive.sv
module fl_drive #(
  parameter int NCUR_W = 4,
  parameter int FCUR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_d,
  input  logic              expire,
  input  logic [NCUR_W-1:0] norm_cur,
  input  logic [FCUR_W-1:0] fl_cur,
  output logic              pin_oe,
  output logic              pin_o,
  output logic [NCUR_W-1:0] cur_sel,
  output logic              done
);
  localparam int PAD_W = NCUR_W - FCUR_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= 1'b0;
      pin_o   <= 1'b0;
      cur_sel <= '0;
      done    <= 1'b0;
    end else begin
      pin_oe  <= run_d;
      pin_o   <= 1'b0;
      cur_sel <= run_d ? {{PAD_W{1'b0}}, fl_cur} : norm_cur;
      done    <= expire;
    end
  end
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq #(
  parameter int REG_W    = 16,
  parameter int FCUR_W   = 2,
  parameter int FINE_W   = 7,
  parameter int COARSE_W = 3,
  parameter int NCUR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              div_upd,
  input  logic [NCUR_W-1:0] norm_cur,
  output logic              fl_pin_oe,
  output logic              fl_pin_o,
  output logic [NCUR_W-1:0] cp_cur_sel,
  output logic              fl_done
);
  localparam int FINE_LSB   = FCUR_W;
  localparam int COARSE_LSB = FINE_LSB + FINE_W;
  localparam int EN_BIT     = COARSE_LSB + COARSE_W;
  localparam int RSV_LSB    = EN_BIT + 1;

  logic [REG_W-1:0]    cfg_q;
  logic                cfg_en;
  logic [COARSE_W-1:0] cfg_coarse;
  logic [FINE_W-1:0]   cfg_fine;
  logic [FCUR_W-1:0]   cfg_fcur;
  logic                run_d;
  logic                expire;

  fl_cfg_reg #(.REG_W(REG_W), .RSV_LSB(RSV_LSB)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  assign cfg_en     = cfg_q[EN_BIT];
  assign cfg_coarse = cfg_q[COARSE_LSB +: COARSE_W];
  assign cfg_fine   = cfg_q[FINE_LSB +: FINE_W];
  assign cfg_fcur   = cfg_q[0 +: FCUR_W];

  fl_timer #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_tmr (
    .clk(clk), .rst(rst), .en(cfg_en), .start(div_upd),
    .coarse(cfg_coarse), .fine(cfg_fine), .run_d(run_d), .expire(expire)
  );

  fl_drive #(.NCUR_W(NCUR_W), .FCUR_W(FCUR_W)) u_drv (
    .clk(clk), .rst(rst), .run_d(run_d), .expire(expire),
    .norm_cur(norm_cur), .fl_cur(cfg_fcur),
    .pin_oe(fl_pin_oe), .pin_o(fl_pin_o), .cur_sel(cp_cur_sel), .done(fl_done)
  );
endmodule

// File: rtl/fastlock_seq_chk.sv
module fastlock_seq_chk #(
  parameter int NCUR_W = 4,
  parameter int FCUR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              div_upd,
  input logic [NCUR_W-1:0] norm_cur,
  input logic              fl_pin_oe,
  input logic [NCUR_W-1:0] cp_cur_sel,
  input logic              fl_done
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (div_upd && cfg_en) |=> fl_pin_oe);

  a_r2_no_start: assert property (@(posedge clk) disable iff (rst)
    (!fl_pin_oe && !cfg_en) |=> !fl_pin_oe);

  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    (fl_pin_oe && !cfg_en) |=> (!fl_pin_oe && !fl_done));

  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    fl_done |=> !fl_done);

  a_r8_at_end: assert property (@(posedge clk) disable iff (rst)
    (seen_q && fl_done) |-> (!fl_pin_oe && $past(fl_pin_oe)));

  a_r5_normal: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !fl_pin_oe) |-> (cp_cur_sel == $past(norm_cur)));

  a_r5_fast_pad: assert property (@(posedge clk) disable iff (rst)
    fl_pin_oe |-> (cp_cur_sel[NCUR_W-1:FCUR_W] == '0));
endmodule

bind fastlock_seq fastlock_seq_chk #(.NCUR_W(NCUR_W), .FCUR_W(FCUR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .div_upd(div_upd),
  .norm_cur(norm_cur), .fl_pin_oe(fl_pin_oe), .cp_cur_sel(cp_cur_sel),
  .fl_done(fl_done)
);

// File: tb/fastlock_seq_bench.sv
`timescale 1ns/1ps
module fastlock_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        div_upd = 1'b0;
  logic [3:0]  norm_cur = '0;
  logic        fl_pin_oe, fl_pin_o, fl_done;
  logic [3:0]  cp_cur_sel;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  fastlock_seq u_fastlock_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .div_upd(div_upd), .norm_cur(norm_cur), .fl_pin_oe(fl_pin_oe),
    .fl_pin_o(fl_pin_o), .cp_cur_sel(cp_cur_sel), .fl_done(fl_done)
  );

  function automatic logic [15:0] mk(bit en, int coarse, int fine, int cur);
    return {3'b000, en, 3'(coarse), 7'(fine), 2'(cur)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); div_upd = 1'b1;
    @(negedge clk); div_upd = 1'b0;
  endtask

  // counts samples with the pin enabled, starting at the current negedge
  task automatic measure(output int cnt, output bit done_at_end);
    cnt = 0;
    while (fl_pin_oe && cnt < 40000) begin
      cnt++;
      @(negedge clk);
    end
    done_at_end = fl_done;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(fl_pin_oe == 0, "R1 oe", fl_pin_oe, 0);
    chk(fl_done == 0, "R1 done", fl_done, 0);
    chk(fl_pin_o == 0, "R1 pin_o", fl_pin_o, 0);
    rst = 1'b0;
    norm_cur = 4'd5;
    @(negedge clk);
    chk(cp_cur_sel == 4'd5, "R5 normal after reset", cp_cur_sel, 5);
    pulse_upd();
    chk(fl_pin_oe == 0, "R1 disabled after reset", fl_pin_oe, 0);
  endtask

  task automatic t_disabled();
    int hits = 0;
    write_cfg(mk(0, 0, 3, 2));
    norm_cur = 4'd9;
    pulse_upd();
    repeat (10) begin
      if (fl_pin_oe) hits++;
      @(negedge clk);
    end
    chk(hits == 0, "R2 no window when disabled", hits, 0);
    chk(cp_cur_sel == 4'd9, "R2 normal code kept", cp_cur_sel, 9);
  endtask

  task automatic t_duration(int coarse, int fine, int cur);
    int cnt; bit d; int exp_n;
    exp_n = (fine + 1) * (1 << coarse);
    write_cfg(mk(1, coarse, fine, cur));
    norm_cur = 4'd12;
    pulse_upd();
    chk(fl_pin_oe == 1, "R3 pin enabled", fl_pin_oe, 1);
    chk(fl_pin_o == 0, "R3 pin driven low", fl_pin_o, 0);
    chk(cp_cur_sel == 4'(cur), "R5 fast code", cp_cur_sel, cur);
    measure(cnt, d);
    chk(cnt == exp_n, "R4 window length", cnt, exp_n);
    chk(d == 1, "R8 done at expiry", d, 1);
    chk(cp_cur_sel == 4'd12, "R5 normal restored", cp_cur_sel, 12);
    @(negedge clk);
    chk(fl_done == 0, "R8 done one cycle", fl_done, 0);
  endtask

  task automatic t_retrigger();
    int cnt; bit d;
    write_cfg(mk(1, 0, 9, 1));
    pulse_upd();
    repeat (3) @(negedge clk);
    chk(fl_pin_oe == 1, "R6 still active", fl_pin_oe, 1);
    pulse_upd();
    measure(cnt, d);
    chk(cnt == 10, "R6 window restarted", cnt, 10);
    chk(d == 1, "R6 done after restart", d, 1);
  endtask

  task automatic t_abort();
    write_cfg(mk(1, 7, 127, 3));
    pulse_upd();
    repeat (5) @(negedge clk);
    write_cfg(mk(0, 7, 127, 3));
    chk(fl_pin_oe == 1, "R7 active at write edge", fl_pin_oe, 1);
    @(negedge clk);
    chk(fl_pin_oe == 0, "R7 released next edge", fl_pin_oe, 0);
    chk(fl_done == 0, "R7 no done on abort", fl_done, 0);
  endtask

  task automatic t_reserved();
    int cnt; bit d; int hits = 0;
    write_cfg(16'hE000 | mk(0, 0, 0, 0));
    pulse_upd();
    repeat (4) begin
      if (fl_pin_oe) hits++;
      @(negedge clk);
    end
    chk(hits == 0, "R9 reserved bits do not enable", hits, 0);
    write_cfg(16'hE000 | mk(1, 0, 2, 2));
    pulse_upd();
    chk(cp_cur_sel == 4'd2, "R9 code unaffected", cp_cur_sel, 2);
    measure(cnt, d);
    chk(cnt == 3, "R9 length unaffected", cnt, 3);
  endtask

  task automatic t_same_cycle();
    int cnt; bit d;
    write_cfg(mk(0, 0, 4, 1));
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = mk(1, 0, 4, 1); div_upd = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; div_upd = 1'b0;
    chk(fl_pin_oe == 0, "R10 strobe used old config", fl_pin_oe, 0);
    write_cfg(mk(1, 1, 1, 2));
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = mk(1, 0, 0, 2); div_upd = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; div_upd = 1'b0;
    measure(cnt, d);
    chk(cnt == 4, "R10 old timer fields used", cnt, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_disabled();
    t_duration(0, 0, 1);
    t_duration(0, 5, 3);
    t_duration(2, 3, 2);
    t_duration(3, 0, 0);
    t_duration(7, 1, 1);
    t_retrigger();
    t_abort();
    t_reserved();
    t_same_cycle();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule